// File: doc/BRIEF.md
# Floating-point result writeback arbiter

This block sits between a set of floating-point pipes and the register files of the clients that issued the operations. Each pipe that has a finished result raises a request naming the client, the base register, the result size in words and the word it wants to write now. A result wider than one register word is written one word per transfer. The block routes each word to base plus word index and marks the target register FULL.

Each client's register file offers one asynchronous write port, a combinational read of the old register state and a write strobe. The block allows at most one writeback per client in a cycle. When several pipes target the same client, the lowest-numbered pipe wins. A write happens only when the port is free and the old register state shows that the register is waiting for a result. A pipe that is not accepted keeps its request and result unchanged until it is accepted, so no result is ever lost. Pipes that target different clients proceed in parallel.

Top module: `fpu_wb_arbiter`

## Requirements
- R1: While rst_ni is low, and up to the first rising clock edge after it is released, no write strobe and no accept is raised.
- R2: The read and write address for a client is the winning pipe's base address plus its word index, modulo 2^ADDR_W.
- R3: With BIG_ENDIAN=0, the written word is the result shifted right by index*WORD_W bits and truncated to WORD_W bits.
- R4: With BIG_ENDIAN=1, the effective index is (words-1-index), and that index is used in place of index when selecting the word.
- R5: Every write carries state FULL, encoded 2'b11. The state encoding is EMPTY=00, PENDING=01, WAITING=10, FULL=11.
- R6: A write happens only when the old state read from the target is PENDING or WAITING. In any other state there is no write and no accept.
- R7: When a client's write port is busy, that client gets no write and no accept.
- R8: Among pipes targeting the same client in a cycle, only the lowest-numbered one can be accepted. Client IDs are binary values on req_client_i.
- R9: Pipes targeting different clients are accepted in the same cycle, one per client.
- R10: An accept is given only together with a write to that pipe's client. A held request that was refused is accepted in a later cycle once it wins and its target is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_PIPES | Per-pipe request valid |
| req_client_i | input | NUM_PIPES*CLIENT_W | Per-pipe target client |
| req_base_i | input | NUM_PIPES*ADDR_W | Per-pipe base register address |
| req_index_i | input | NUM_PIPES*IDX_W | Per-pipe word index being written |
| req_words_i | input | NUM_PIPES*CNT_W | Per-pipe result size in words (1..MAX_WORDS) |
| req_value_i | input | NUM_PIPES*MAX_WORDS*WORD_W | Per-pipe full result value |
| accept_o | output | NUM_PIPES | Per-pipe word accepted this cycle |
| rf_busy_i | input | NUM_CLIENTS | Per-client write port busy |
| rf_rd_addr_o | output | NUM_CLIENTS*ADDR_W | Per-client address of the old-state read |
| rf_rd_state_i | input | NUM_CLIENTS*2 | Per-client old register state |
| rf_we_o | output | NUM_CLIENTS | Per-client write strobe |
| rf_wr_addr_o | output | NUM_CLIENTS*ADDR_W | Per-client write address |
| rf_wr_data_o | output | NUM_CLIENTS*WORD_W | Per-client write data |
| rf_wr_state_o | output | NUM_CLIENTS*2 | Per-client written state |

## Verification
Priority arbitration and the readiness check can decide the same cycle. A lower pipe can win a client whose register is not ready or whose port is busy, which stalls every pipe that targets that client. The sweep covers every assignment of three pipes to two clients, together with every pair of old states and every busy pattern. For each cycle it computes the winner and the readiness outcome per client and compares them with the accepts and writes. Directed steps then hold a refused request and check that it is accepted once the lower pipe has drained.

// File: rtl/fpu_wb_pkg.sv
package fpu_wb_pkg;
  typedef enum logic [1:0] {
    REG_EMPTY   = 2'b00,
    REG_PENDING = 2'b01,
    REG_WAITING = 2'b10,
    REG_FULL    = 2'b11
  } reg_state_e;
endpackage

// File: rtl/fpu_wb_word_sel.sv
module fpu_wb_word_sel #(
  parameter int WORD_W     = 8,
  parameter int MAX_WORDS  = 4,
  parameter bit BIG_ENDIAN = 1'b0,
  localparam int IDX_W = $clog2(MAX_WORDS),
  localparam int CNT_W = IDX_W + 1,
  localparam int VAL_W = WORD_W * MAX_WORDS
) (
  input  logic [VAL_W-1:0]  value_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic [CNT_W-1:0]  words_i,
  output logic [WORD_W-1:0] word_o
);
  logic [CNT_W-1:0] eff_idx;
  logic [VAL_W-1:0] shifted;

  generate
    if (BIG_ENDIAN) begin : g_be
      assign eff_idx = words_i - CNT_W'(1) - CNT_W'(index_i);
    end else begin : g_le
      assign eff_idx = CNT_W'(index_i);
    end
  endgenerate

  assign shifted = value_i >> (int'(eff_idx) * WORD_W);
  assign word_o  = shifted[WORD_W-1:0];
endmodule

// File: rtl/fpu_wb_client_port.sv
module fpu_wb_client_port
  import fpu_wb_pkg::*;
#(
  parameter int NUM_PIPES = 3,
  parameter int ADDR_W    = 4,
  parameter int WORD_W    = 8,
  localparam int SEL_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic [NUM_PIPES-1:0]        hit_i,
  input  logic [NUM_PIPES*ADDR_W-1:0] addr_i,
  input  logic [NUM_PIPES*WORD_W-1:0] word_i,
  input  logic                        busy_i,
  input  logic [1:0]                  rd_state_i,
  output logic [ADDR_W-1:0]           rd_addr_o,
  output logic                        we_o,
  output logic [ADDR_W-1:0]           wr_addr_o,
  output logic [WORD_W-1:0]           wr_data_o,
  output logic [1:0]                  wr_state_o,
  output logic [NUM_PIPES-1:0]        grant_o
);
  logic             found;
  logic [SEL_W-1:0] sel;
  logic             ready;

  // fixed priority: lowest pipe number
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int p = 0; p < NUM_PIPES; p++) begin
      if (hit_i[p] && !found) begin
        found = 1'b1;
        sel   = SEL_W'(p);
      end
    end
  end

  assign ready      = (rd_state_i == REG_PENDING) || (rd_state_i == REG_WAITING);
  assign rd_addr_o  = addr_i[sel*ADDR_W +: ADDR_W];
  assign we_o       = en_i && found && !busy_i && ready;
  assign wr_addr_o  = rd_addr_o;
  assign wr_data_o  = word_i[sel*WORD_W +: WORD_W];
  assign wr_state_o = REG_FULL;
  assign grant_o    = we_o ? (NUM_PIPES'(1) << sel) : '0;

  AST_WE_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (rd_state_i == REG_PENDING || rd_state_i == REG_WAITING)); // R6
  AST_WE_PORT_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> !busy_i); // R7
  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R8
  AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0) |-> ((hit_i & (grant_o - NUM_PIPES'(1))) == '0)); // R8
endmodule

// File: rtl/fpu_wb_arbiter.sv
module fpu_wb_arbiter
  import fpu_wb_pkg::*;
#(
  parameter int NUM_PIPES   = 3,
  parameter int NUM_CLIENTS = 2,
  parameter int ADDR_W      = 4,
  parameter int WORD_W      = 8,
  parameter int MAX_WORDS   = 4,
  parameter bit BIG_ENDIAN  = 1'b0,
  localparam int CLIENT_W = $clog2(NUM_CLIENTS),
  localparam int IDX_W    = $clog2(MAX_WORDS),
  localparam int CNT_W    = IDX_W + 1,
  localparam int VAL_W    = WORD_W * MAX_WORDS
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_PIPES-1:0]            req_valid_i,
  input  logic [NUM_PIPES*CLIENT_W-1:0]   req_client_i,
  input  logic [NUM_PIPES*ADDR_W-1:0]     req_base_i,
  input  logic [NUM_PIPES*IDX_W-1:0]      req_index_i,
  input  logic [NUM_PIPES*CNT_W-1:0]      req_words_i,
  input  logic [NUM_PIPES*VAL_W-1:0]      req_value_i,
  output logic [NUM_PIPES-1:0]            accept_o,
  input  logic [NUM_CLIENTS-1:0]          rf_busy_i,
  output logic [NUM_CLIENTS*ADDR_W-1:0]   rf_rd_addr_o,
  input  logic [NUM_CLIENTS*2-1:0]        rf_rd_state_i,
  output logic [NUM_CLIENTS-1:0]          rf_we_o,
  output logic [NUM_CLIENTS*ADDR_W-1:0]   rf_wr_addr_o,
  output logic [NUM_CLIENTS*WORD_W-1:0]   rf_wr_data_o,
  output logic [NUM_CLIENTS*2-1:0]        rf_wr_state_o
);
  logic                        en_q;
  logic [NUM_PIPES*ADDR_W-1:0] tgt_addr;
  logic [NUM_PIPES*WORD_W-1:0] tgt_word;
  logic [NUM_PIPES-1:0]        grant_c [NUM_CLIENTS];

  // writes open one edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= 1'b1;
  end

  generate
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
      assign tgt_addr[p*ADDR_W +: ADDR_W] =
        req_base_i[p*ADDR_W +: ADDR_W] + ADDR_W'(req_index_i[p*IDX_W +: IDX_W]);

      fpu_wb_word_sel #(
        .WORD_W    (WORD_W),
        .MAX_WORDS (MAX_WORDS),
        .BIG_ENDIAN(BIG_ENDIAN)
      ) u_sel (
        .value_i(req_value_i[p*VAL_W +: VAL_W]),
        .index_i(req_index_i[p*IDX_W +: IDX_W]),
        .words_i(req_words_i[p*CNT_W +: CNT_W]),
        .word_o (tgt_word[p*WORD_W +: WORD_W])
      );

      AST_ACCEPT_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o[p] |-> rf_we_o[req_client_i[p*CLIENT_W +: CLIENT_W]]); // R10
    end

    for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_client
      logic [NUM_PIPES-1:0] hit;
      always_comb begin
        for (int p = 0; p < NUM_PIPES; p++)
          hit[p] = req_valid_i[p] &&
                   (req_client_i[p*CLIENT_W +: CLIENT_W] == CLIENT_W'(c));
      end

      fpu_wb_client_port #(
        .NUM_PIPES(NUM_PIPES),
        .ADDR_W   (ADDR_W),
        .WORD_W   (WORD_W)
      ) u_port (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_q),
        .hit_i     (hit),
        .addr_i    (tgt_addr),
        .word_i    (tgt_word),
        .busy_i    (rf_busy_i[c]),
        .rd_state_i(rf_rd_state_i[c*2 +: 2]),
        .rd_addr_o (rf_rd_addr_o[c*ADDR_W +: ADDR_W]),
        .we_o      (rf_we_o[c]),
        .wr_addr_o (rf_wr_addr_o[c*ADDR_W +: ADDR_W]),
        .wr_data_o (rf_wr_data_o[c*WORD_W +: WORD_W]),
        .wr_state_o(rf_wr_state_o[c*2 +: 2]),
        .grant_o   (grant_c[c])
      );
    end
  endgenerate

  always_comb begin
    accept_o = '0;
    for (int c = 0; c < NUM_CLIENTS; c++) accept_o |= grant_c[c];
  end

  AST_ACCEPT_NEEDS_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o == '0) |-> (accept_o == '0)); // R10
endmodule

// File: tb/fpu_wb_arbiter_tb_top.sv
module fpu_wb_arbiter_tb_top;
  localparam int NP = 3, NC = 2, AW = 4, WW = 8, MW = 4;
  localparam int CW = 1, IW = 2, SW = 3, VW = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic          v   [NP];
  logic [CW-1:0] cl  [NP];
  logic [AW-1:0] bs  [NP];
  logic [IW-1:0] ix  [NP];
  logic [SW-1:0] wd  [NP];
  logic [VW-1:0] val [NP];
  logic [1:0]    st  [NC];
  logic          bz  [NC];

  logic [NP-1:0]    req_valid;
  logic [NP*CW-1:0] req_client;
  logic [NP*AW-1:0] req_base;
  logic [NP*IW-1:0] req_index;
  logic [NP*SW-1:0] req_words;
  logic [NP*VW-1:0] req_value;
  logic [NC-1:0]    busy;
  logic [NC*2-1:0]  rd_state;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      req_valid[p] = v[p];
      req_client[p*CW +: CW] = cl[p];
      req_base[p*AW +: AW] = bs[p];
      req_index[p*IW +: IW] = ix[p];
      req_words[p*SW +: SW] = wd[p];
      req_value[p*VW +: VW] = val[p];
    end
    for (int c = 0; c < NC; c++) begin
      busy[c] = bz[c];
      rd_state[c*2 +: 2] = st[c];
    end
  end

  logic [NP-1:0]    acc_le, acc_be;
  logic [NC*AW-1:0] rda_le, rda_be, wra_le, wra_be;
  logic [NC-1:0]    we_le, we_be;
  logic [NC*WW-1:0] wrd_le, wrd_be;
  logic [NC*2-1:0]  wrs_le, wrs_be;

  fpu_wb_arbiter #(.BIG_ENDIAN(1'b0)) dut_i (
    .clk_i, .rst_ni, .req_valid_i(req_valid), .req_client_i(req_client),
    .req_base_i(req_base), .req_index_i(req_index), .req_words_i(req_words),
    .req_value_i(req_value), .accept_o(acc_le), .rf_busy_i(busy),
    .rf_rd_addr_o(rda_le), .rf_rd_state_i(rd_state), .rf_we_o(we_le),
    .rf_wr_addr_o(wra_le), .rf_wr_data_o(wrd_le), .rf_wr_state_o(wrs_le));

  fpu_wb_arbiter #(.BIG_ENDIAN(1'b1)) dut_be_i (
    .clk_i, .rst_ni, .req_valid_i(req_valid), .req_client_i(req_client),
    .req_base_i(req_base), .req_index_i(req_index), .req_words_i(req_words),
    .req_value_i(req_value), .accept_o(acc_be), .rf_busy_i(busy),
    .rf_rd_addr_o(rda_be), .rf_rd_state_i(rd_state), .rf_we_o(we_be),
    .rf_wr_addr_o(wra_be), .rf_wr_data_o(wrd_be), .rf_wr_state_o(wrs_be));

  int n_chk = 0, n_err = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [WW-1:0] pick(logic [VW-1:0] x, int idx, int words, bit be);
    int e = be ? (words - 1 - idx) : idx;
    return WW'(x >> (e * WW));
  endfunction

  // full model comparison for both variants
  task automatic check_all();
    logic [NP-1:0] exp_acc = '0;
    for (int c = 0; c < NC; c++) begin
      int win = -1;
      bit ok;
      for (int p = NP - 1; p >= 0; p--) if (v[p] && cl[p] == CW'(c)) win = p;
      ok = (win >= 0) && !bz[c] && (st[c] == 2'b01 || st[c] == 2'b10);
      chk(bz[c] ? "R7 we_le" : "R6 we_le", 32'(we_le[c]), 32'(ok));
      chk(bz[c] ? "R7 we_be" : "R6 we_be", 32'(we_be[c]), 32'(ok));
      if (ok) begin
        logic [AW-1:0] a = bs[win] + AW'(ix[win]);
        exp_acc[win] = 1'b1;
        chk("R2 rd_addr", 32'(rda_le[c*AW +: AW]), 32'(a));
        chk("R2 wr_addr", 32'(wra_be[c*AW +: AW]), 32'(a));
        chk("R3 data_le", 32'(wrd_le[c*WW +: WW]), 32'(pick(val[win], ix[win], wd[win], 1'b0)));
        chk("R4 data_be", 32'(wrd_be[c*WW +: WW]), 32'(pick(val[win], ix[win], wd[win], 1'b1)));
        chk("R5 state", 32'(wrs_le[c*2 +: 2]), 32'h3);
      end
    end
    chk("R8 accept_le", 32'(acc_le), 32'(exp_acc));
    chk("R8 accept_be", 32'(acc_be), 32'(exp_acc));
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      v[p] = 1'b1; cl[p] = CW'(p % 2); bs[p] = AW'(p); ix[p] = '0;
      wd[p] = 3'd1; val[p] = 32'h11223344;
    end
    for (int c = 0; c < NC; c++) begin st[c] = 2'b01; bz[c] = 1'b0; end
    // R1: ready requests during reset
    @(posedge clk_i); #1;
    chk("R1 we in reset", 32'(we_le), 32'h0);
    chk("R1 accept in reset", 32'(acc_le), 32'h0);
    @(negedge clk_i); rst_ni = 1'b1; #1;
    chk("R1 we before first edge", 32'(we_le), 32'h0);
    @(posedge clk_i);

    // sweep: pipe->client assignments x states x busy patterns
    for (int pat = 0; pat < 27; pat++) begin
      for (int sb = 0; sb < 64; sb++) begin
        @(negedge clk_i);
        for (int p = 0; p < NP; p++) begin
          int code = (pat / (p == 0 ? 1 : (p == 1 ? 3 : 9))) % 3;
          v[p]   = (code != 0);
          cl[p]  = CW'(code == 2);
          wd[p]  = SW'((pat + p) % 4 + 1);
          ix[p]  = IW'((pat * 3 + p + sb) % ((pat + p) % 4 + 1));
          bs[p]  = AW'(p * 5 + pat + sb);
          val[p] = {8'(p * 16 + pat), 8'(pat + 8'h40), 8'(~pat), 8'(p + 8'hA5)};
        end
        st[0] = 2'(sb % 4); st[1] = 2'((sb / 4) % 4);
        bz[0] = sb[4];      bz[1] = sb[5];
        #2 check_all();
      end
    end

    // R9: two clients served in parallel
    @(negedge clk_i);
    v[0] = 1; cl[0] = 0; v[1] = 1; cl[1] = 1; v[2] = 0;
    st[0] = 2'b10; st[1] = 2'b01; bz[0] = 0; bz[1] = 0;
    #2 chk("R9 parallel accept", 32'(acc_le), 32'h3);

    // R10: refused pipe held, accepted once lower pipe drains
    @(negedge clk_i);
    v[0] = 1; cl[0] = 1; v[1] = 1; cl[1] = 1; v[2] = 0; st[1] = 2'b01;
    #2 chk("R10 first only", 32'(acc_le), 32'h1);
    @(negedge clk_i); v[0] = 0;
    #2 chk("R10 held accepted", 32'(acc_le), 32'h2);
    // R10: too-early result waits, then goes
    @(negedge clk_i); st[1] = 2'b11;
    #2 chk("R10 early refused", 32'(acc_le), 32'h0);
    @(negedge clk_i); st[1] = 2'b10;
    #2 chk("R10 later accepted", 32'(acc_le), 32'h2);
    chk("R5 written state", 32'(wrs_be[3:2]), 32'h3);

    @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule